// File: doc/BRIEF.md
# Accumulator Arithmetic Logic Unit

This block is the combinational datapath of a small accumulator machine. It takes the current accumulator value and a data operand, and a 4-bit function code picks one of ten operations. The block returns the result together with a carry/borrow flag and a zero flag. Outputs follow the inputs with no clock and no state. The register that holds the accumulator, the capture of operands and any display of results stay with the surrounding logic.

Carry has its own rule for each function. Add reports the carry out of the top bit. Subtract reports a borrow. Complement always raises the flag. The three shifts copy the bit pushed out of the word into the flag. Functions that have no natural carry drive it low. The six codes that name no function give a defined, quiet output: a zero result with the zero flag set.

The datapath has no flow of packets and no back-pressure, so every pin is a plain level signal.

Top module: `acc_alu`

## Requirements
- R1: For every function code, `zero_out` is 1 when all bits of `result_out` are 0, and 0 in every other case.
- R2: Code 0 (load) gives `result_out = data_in` and `carry_out = 0`.
- R3: Code 1 (add) gives `result_out = (acc_in + data_in) mod 2^WIDTH`, with `carry_out` equal to the carry out of the most significant bit.
- R4: Code 2 (subtract) gives `result_out = (acc_in - data_in) mod 2^WIDTH`, with `carry_out = 1` exactly when `data_in > acc_in` as unsigned values.
- R5: Code 3 gives the bitwise AND of the two operands and code 4 gives their bitwise OR. Both drive `carry_out = 0`.
- R6: Code 5 (complement) gives the bitwise inverse of `acc_in` and always drives `carry_out = 1`.
- R7: Code 6 (increment) gives `(acc_in + 1) mod 2^WIDTH` with `carry_out = 0`. This includes the wrap from all ones to zero.
- R8: Code 7 (logical shift right) gives `{0, acc_in[WIDTH-1:1]}` with `carry_out = acc_in[0]`.
- R9: Code 8 (logical shift left) gives `{acc_in[WIDTH-2:0], 0}` with `carry_out = acc_in[WIDTH-1]`.
- R10: Code 9 (shift right with bit 0 fed to the top) gives `{acc_in[0], acc_in[WIDTH-1:1]}` with `carry_out = acc_in[0]`.
- R11: Codes 10 to 15 give `result_out = 0`, `carry_out = 0` and `zero_out = 1`, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_in | input | WIDTH (8) | Accumulator operand |
| data_in | input | WIDTH (8) | Data operand |
| func_sel | input | 4 | Function code, 0 to 15 |
| result_out | output | WIDTH (8) | Operation result |
| carry_out | output | 1 | Carry, borrow or shifted-out bit |
| zero_out | output | 1 | High when the result is all zeros |

## Verification
Uniformly random operands paired with every function code check the general arithmetic and logic. They separate a correct carry from a wrong carry source in add and subtract. They also catch a shift that is off by one position.

Directed operands target the edges:
- all-ones plus one, which exposes the carry out of the top bit and a zero result together;
- equal and reversed operands for subtract, which exposes the borrow polarity;
- single-bit values at either end of the word, which show whether each shift fills its vacated bit and sets the flag correctly;
- the wrap in increment, which shows that the carry stays low.

Random operands sent with the unused codes confirm that those codes never leak an operand into the outputs.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    FN_LOAD = 4'd0,
    FN_ADD  = 4'd1,
    FN_SUB  = 4'd2,
    FN_AND  = 4'd3,
    FN_OR   = 4'd4,
    FN_COM  = 4'd5,
    FN_INC  = 4'd6,
    FN_LSR  = 4'd7,
    FN_LSL  = 4'd8,
    FN_ASR  = 4'd9
  } fn_e;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             sum_c_o,
  output logic [WIDTH-1:0] diff_o,
  output logic             borrow_o,
  output logic [WIDTH-1:0] inc_o
);
  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] sum_ext;
  logic [EXT_W-1:0] diff_ext;

  always_comb begin
    sum_ext  = {1'b0, a_i} + {1'b0, b_i};
    diff_ext = {1'b0, a_i} - {1'b0, b_i};
    sum_o    = sum_ext[WIDTH-1:0];
    sum_c_o  = sum_ext[WIDTH];
    diff_o   = diff_ext[WIDTH-1:0];
    borrow_o = diff_ext[WIDTH];
    inc_o    = a_i + {{(WIDTH-1){1'b0}}, 1'b1};
  end

  // The borrow bit of the extended difference must agree with an unsigned compare.
  always_comb begin
    a_r4_borrow_matches_compare: assert (borrow_o == (b_i > a_i))
      else $error("borrow disagrees with unsigned compare");
    // The add result must return the original accumulator once the data operand is taken off again.
    a_r3_sum_roundtrip: assert ((sum_o - b_i) == a_i)
      else $error("sum does not invert through subtraction");
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] com_o
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign and_o[gi] = a_i[gi] & b_i[gi];
      assign or_o[gi]  = a_i[gi] | b_i[gi];
      assign com_o[gi] = ~a_i[gi];
    end
  endgenerate

  // The AND result is always contained in the OR result.
  always_comb begin
    a_r5_and_within_or: assert ((and_o & ~or_o) == '0)
      else $error("AND result has bits outside the OR result");
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] lsr_o,
  output logic             lsr_c_o,
  output logic [WIDTH-1:0] lsl_o,
  output logic             lsl_c_o,
  output logic [WIDTH-1:0] asr_o,
  output logic             asr_c_o
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH - 1; gi++) begin : g_move
      assign lsr_o[gi]     = a_i[gi+1];
      assign asr_o[gi]     = a_i[gi+1];
      assign lsl_o[gi+1]   = a_i[gi];
    end
  endgenerate

  assign lsr_o[WIDTH-1] = 1'b0;
  assign asr_o[WIDTH-1] = a_i[0];
  assign lsl_o[0]       = 1'b0;
  assign lsr_c_o        = a_i[0];
  assign asr_c_o        = a_i[0];
  assign lsl_c_o        = a_i[WIDTH-1];

  always_comb begin
    a_r8_lsr_matches_builtin: assert (lsr_o == (a_i >> 1))
      else $error("right shift disagrees with operator");
    a_r9_lsl_matches_builtin: assert (lsl_o == (a_i << 1))
      else $error("left shift disagrees with operator");
    a_r10_asr_is_lsr_plus_top: assert ((asr_o ^ lsr_o) == {a_i[0], {(WIDTH-1){1'b0}}})
      else $error("feed-back shift differs beyond its top bit");
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_in,
  input  logic [WIDTH-1:0] data_in,
  input  logic [3:0]       func_sel,
  output logic [WIDTH-1:0] result_out,
  output logic             carry_out,
  output logic             zero_out
);
  localparam int FN_COUNT = 10;

  logic [WIDTH-1:0] sum_w, diff_w, inc_w;
  logic             sum_c_w, borrow_w;
  logic [WIDTH-1:0] and_w, or_w, com_w;
  logic [WIDTH-1:0] lsr_w, lsl_w, asr_w;
  logic             lsr_c_w, lsl_c_w, asr_c_w;

  acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i      (acc_in),
    .b_i      (data_in),
    .sum_o    (sum_w),
    .sum_c_o  (sum_c_w),
    .diff_o   (diff_w),
    .borrow_o (borrow_w),
    .inc_o    (inc_w)
  );

  acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (acc_in),
    .b_i   (data_in),
    .and_o (and_w),
    .or_o  (or_w),
    .com_o (com_w)
  );

  acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i     (acc_in),
    .lsr_o   (lsr_w),
    .lsr_c_o (lsr_c_w),
    .lsl_o   (lsl_w),
    .lsl_c_o (lsl_c_w),
    .asr_o   (asr_w),
    .asr_c_o (asr_c_w)
  );

  always_comb begin
    result_out = '0;
    carry_out  = 1'b0;
    case (func_sel)
      FN_LOAD: result_out = data_in;
      FN_ADD:  begin result_out = sum_w;  carry_out = sum_c_w;  end
      FN_SUB:  begin result_out = diff_w; carry_out = borrow_w; end
      FN_AND:  result_out = and_w;
      FN_OR:   result_out = or_w;
      FN_COM:  begin result_out = com_w;  carry_out = 1'b1;     end
      FN_INC:  result_out = inc_w;
      FN_LSR:  begin result_out = lsr_w;  carry_out = lsr_c_w;  end
      FN_LSL:  begin result_out = lsl_w;  carry_out = lsl_c_w;  end
      FN_ASR:  begin result_out = asr_w;  carry_out = asr_c_w;  end
      default: begin result_out = '0;     carry_out = 1'b0;     end
    endcase
    zero_out = ~|result_out;
  end

  always_comb begin
    if (int'(func_sel) >= FN_COUNT) begin
      a_r11_unused_quiet: assert (result_out == '0 && !carry_out && zero_out)
        else $error("unused code produced non-quiet output");
    end
    if (func_sel == FN_COM) begin
      a_r6_com_sets_carry: assert (carry_out && ((result_out ^ acc_in) == '1))
        else $error("complement carry or value wrong");
    end
    if (func_sel == FN_INC) begin
      a_r7_inc_no_carry: assert (!carry_out && (result_out - acc_in) == {{(WIDTH-1){1'b0}}, 1'b1})
        else $error("increment value or carry wrong");
    end
  end
endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc_in = '0;
  logic [7:0] data_in = '0;
  logic [3:0] func_sel = '0;
  logic [7:0] result_out;
  logic       carry_out;
  logic       zero_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu #(.WIDTH(8)) uut (
    .acc_in     (acc_in),
    .data_in    (data_in),
    .func_sel   (func_sel),
    .result_out (result_out),
    .carry_out  (carry_out),
    .zero_out   (zero_out)
  );

  function automatic string req_of(input logic [3:0] f);
    case (f)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Returns {carry, result} from the requirement text.
  function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] d, input logic [3:0] f);
    logic [8:0] t;
    case (f)
      4'd0: return {1'b0, d};
      4'd1: begin t = {1'b0, a} + {1'b0, d}; return t; end
      4'd2: return {(d > a), 8'(a - d)};
      4'd3: return {1'b0, a & d};
      4'd4: return {1'b0, a | d};
      4'd5: return {1'b1, ~a};
      4'd6: return {1'b0, 8'(a + 8'd1)};
      4'd7: return {a[0], 1'b0, a[7:1]};
      4'd8: return {a[7], a[6:0], 1'b0};
      4'd9: return {a[0], a[0], a[7:1]};
      default: return 9'd0;
    endcase
  endfunction

  task automatic apply(input logic [7:0] a, input logic [7:0] d, input logic [3:0] f);
    logic [8:0] exp_v;
    logic       exp_z;
    @(negedge clk);
    acc_in = a; data_in = d; func_sel = f;
    #1;
    exp_v = model(a, d, f);
    exp_z = (exp_v[7:0] == 8'd0);
    checks++;
    if (result_out !== exp_v[7:0] || carry_out !== exp_v[8]) begin
      errors++;
      $display("FAIL %s code=%0d a=%02h d=%02h: result=%02h carry=%0b, expected result=%02h carry=%0b",
               req_of(f), f, a, d, result_out, carry_out, exp_v[7:0], exp_v[8]);
    end
    checks++;
    if (zero_out !== exp_z) begin
      errors++;
      $display("FAIL R1 code=%0d a=%02h d=%02h: zero=%0b, expected zero=%0b", f, a, d, zero_out, exp_z);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Initial state: all-zero inputs, load code (R2, R1)
    apply(8'h00, 8'h00, 4'd0);
    // Directed corners
    apply(8'h3C, 8'hA5, 4'd0);   // R2 load
    apply(8'hFF, 8'h01, 4'd1);   // R3 carry out with zero result
    apply(8'h12, 8'h34, 4'd1);   // R3 no carry
    apply(8'h05, 8'h05, 4'd2);   // R4 equal, no borrow, zero
    apply(8'h03, 8'h04, 4'd2);   // R4 borrow
    apply(8'hF0, 8'h0F, 4'd3);   // R5 disjoint AND gives zero
    apply(8'hF0, 8'h0F, 4'd4);   // R5 OR fills word
    apply(8'hFF, 8'h00, 4'd5);   // R6 zero result, carry high
    apply(8'h5A, 8'h00, 4'd5);   // R6
    apply(8'hFF, 8'h77, 4'd6);   // R7 wrap, carry stays low
    apply(8'h7F, 8'h00, 4'd6);   // R7
    apply(8'h01, 8'h00, 4'd7);   // R8 bit out, zero result
    apply(8'h80, 8'h00, 4'd7);   // R8 top fill is zero
    apply(8'h80, 8'h00, 4'd8);   // R9 bit out, zero result
    apply(8'h01, 8'h00, 4'd8);   // R9 bottom fill is zero
    apply(8'h01, 8'h00, 4'd9);   // R10 bit 0 lands in top
    apply(8'h80, 8'h00, 4'd9);   // R10 no feed-back
    for (int f = 10; f < 16; f++) apply(8'hFF, 8'hFF, 4'(f)); // R11
    // Random operands across all codes
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      apply(8'($urandom), 8'($urandom), 4'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycles=%0d, expected completion before 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule